// File: doc/BRIEF.md
# Wiper Register with Banked Presets

This block is the digital control core of a digitally controlled potentiometer. It holds a volatile 8-bit wiper code and drives a 256-line one-hot tap select from it. Line 0 is the tap at the low terminal and line 255 is the tap at the high terminal. Next to the wiper sits a file of sixteen 8-bit presets, arranged as four banks of four. The presets model stored settings. A preset write starts a programming interval, and while that interval runs the block reports busy.

A serial front end, which is outside this block, sends one request per cycle. Each request carries an operation code, a bank, a register index and a data byte. The operations are:
- read or write the wiper;
- read or write a preset;
- load a preset into the wiper;
- store the wiper into a preset;
- step the wiper one tap up or down.

Each request gets a response exactly one cycle later, with an accept flag and a read data byte. On reset the wiper takes the value held in bank 0 register 0. A write-protect input guards the presets only.

Top module: `wiper_preset_core`

## Requirements
- R1: While `rst` is high at a clock edge, every preset takes its slot from `PRESET_INIT`, with slot s = bank*4+index in bits [8s+7:8s]. After that edge the wiper equals slot 0, `busy` is low and `rsp_valid` is low.
- R2: `tap_sel` always has exactly one bit set, and that bit's index equals the wiper code. Code 0x00 sets bit 0, the low-terminal end, and code 0xFF sets bit 255, the high-terminal end.
- R3: Operation 2 (wiper write) loads `req_wdata` into the wiper. It is accepted whatever the state of `wr_protect` and `busy`. Operation 1 (wiper read) returns the wiper value held in the cycle of the request.
- R4: Operation 4 (preset write), when accepted, stores `req_wdata` into slot {bank,index}. Operation 3 (preset read) returns that slot, and a value written is visible to a read in the very next cycle.
- R5: Operation 5 (load) copies slot {bank,index} into the wiper.
- R6: Operation 6 (store) copies the current wiper into slot {bank,index}. It follows the same protect and busy rules as a preset write.
- R7: Operation 7 steps the wiper by one tap: up when `req_wdata[0]` is 1 and down when it is 0. A step up at 0xFF leaves 0xFF, and a step down at 0x00 leaves 0x00.
- R8: While `wr_protect` is high, operations 4 and 6 are rejected: `rsp_ok` is 0 and no preset changes.
- R9: An accepted preset write or store holds `busy` high for exactly `PROG_CYCLES` cycles after its clock edge. Operations 4 and 6 arriving while `busy` is high are rejected. All other operations are still accepted during that time.
- R10: A request with `req_valid` high produces `rsp_valid` high in the next cycle. `rsp_data` carries the value read for operations 1 and 3 and is 0 for every other operation. `rsp_ok` is 1 unless R8 or R9 rejects the request. Operation 0 is a no-op, and no response is given without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0..7, see requirements) |
| req_bank | input | 2 | Preset bank |
| req_idx | input | 2 | Register index within bank |
| req_wdata | input | 8 | Write data; bit 0 is the step direction |
| wr_protect | input | 1 | High blocks preset writes and stores |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_ok | output | 1 | Request was accepted |
| rsp_data | output | 8 | Read data |
| busy | output | 1 | Preset programming interval running |
| wiper | output | 8 | Current wiper code |
| tap_sel | output | 256 | One-hot tap select |

## Verification
The directed part of the bench targets the following cases:
- Wiper writes of 0x00 and 0xFF, which separate the two end taps and the decode at each boundary.
- Steps pushed against both ends, which show whether the counter saturates or wraps.
- A preset write followed at once by another write, by a store and by reads. This tells a rejection caused by busy apart from one caused by protect, and shows that reads and wiper writes still go through during busy.

After the directed part, a pseudo-random stream mixes every operation, including write-protect toggles. Each cycle the outputs are compared with a behavioural model. This catches errors in slot addressing and in the length of the busy interval.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    localparam int CODE_W   = 8;
    localparam int BANKS    = 4;
    localparam int PER_BANK = 4;
    localparam int BANK_W   = $clog2(BANKS);
    localparam int IDX_W    = $clog2(PER_BANK);
    localparam int SLOT_W   = BANK_W + IDX_W;
    localparam int SLOTS    = BANKS * PER_BANK;
    localparam int TAPS     = 1 << CODE_W;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_RD_WIPER  = 3'd1,
        OP_WR_WIPER  = 3'd2,
        OP_RD_PRESET = 3'd3,
        OP_WR_PRESET = 3'd4,
        OP_LOAD      = 3'd5,
        OP_STORE     = 3'd6,
        OP_STEP      = 3'd7
    } wpc_op_e;

    typedef enum logic [1:0] {
        WCMD_HOLD = 2'd0,
        WCMD_LOAD = 2'd1,
        WCMD_UP   = 2'd2,
        WCMD_DOWN = 2'd3
    } wpc_wcmd_e;

    typedef struct packed {
        wpc_op_e             op;
        logic [BANK_W-1:0]   bank;
        logic [IDX_W-1:0]    idx;
        logic [CODE_W-1:0]   data;
    } wpc_req_t;

    typedef struct packed {
        logic              valid;
        logic              ok;
        logic [CODE_W-1:0] data;
    } wpc_rsp_t;

    function automatic logic [SLOT_W-1:0] slot_of(logic [BANK_W-1:0] b,
                                                  logic [IDX_W-1:0] i);
        return {b, i};
    endfunction

    function automatic logic [CODE_W-1:0] sat_step(logic [CODE_W-1:0] v, logic up);
        logic [CODE_W-1:0] r;
        if (up) r = (v == {CODE_W{1'b1}}) ? v : v + 1'b1;
        else    r = (v == '0) ? v : v - 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/wpc_preset_file.sv
module wpc_preset_file
    import wpc_pkg::*;
#(
    parameter int PROG_CYCLES = 20,
    parameter logic [SLOTS*CODE_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  logic [CODE_W-1:0] wdata,
    input  logic [SLOT_W-1:0] raddr,
    output logic [CODE_W-1:0] rdata,
    output logic              busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES);

    logic [SLOTS-1:0][CODE_W-1:0] slot_q;
    logic [CNT_W-1:0]             cnt_q;

    genvar s;
    generate
        for (s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    slot_q[s] <= INIT[s*CODE_W +: CODE_W];
                else if (we && waddr == SLOT_W'(s))
                    slot_q[s] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (we)
            cnt_q <= CNT_LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign rdata = slot_q[raddr];
    assign busy  = (cnt_q != '0);
endmodule

// File: rtl/wpc_wiper_reg.sv
module wpc_wiper_reg
    import wpc_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  wpc_wcmd_e         cmd,
    input  logic [CODE_W-1:0] load_val,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] code_q, code_d;

    always_comb begin
        unique case (cmd)
            WCMD_LOAD: code_d = load_val;
            WCMD_UP:   code_d = sat_step(code_q, 1'b1);
            WCMD_DOWN: code_d = sat_step(code_q, 1'b0);
            default:   code_d = code_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) code_q <= RESET_VAL;
        else     code_q <= code_d;
    end

    assign code = code_q;
endmodule

// File: rtl/wpc_tap_decode.sv
module wpc_tap_decode
    import wpc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [TAPS-1:0]   tap
);
    genvar t;
    generate
        for (t = 0; t < TAPS; t++) begin : g_tap
            assign tap[t] = (code == CODE_W'(t));
        end
    endgenerate
endmodule

// File: rtl/wiper_preset_core.sv
module wiper_preset_core
    import wpc_pkg::*;
#(
    parameter int PROG_CYCLES = 20,
    parameter logic [SLOTS*CODE_W-1:0] PRESET_INIT =
        128'hf0e1d2c3_b4a59687_78695a4b_3c2d1e80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [1:0]        req_bank,
    input  logic [1:0]        req_idx,
    input  logic [7:0]        req_wdata,
    input  logic              wr_protect,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [7:0]        rsp_data,
    output logic              busy,
    output logic [7:0]        wiper,
    output logic [255:0]      tap_sel
);
    localparam logic [CODE_W-1:0] RECALL_VAL = PRESET_INIT[CODE_W-1:0];

    wpc_req_t          rq;
    wpc_rsp_t          rsp_d, rsp_q;
    wpc_wcmd_e         wcmd;
    logic [CODE_W-1:0] wload;
    logic [SLOT_W-1:0] addr;
    logic              pf_we;
    logic [CODE_W-1:0] pf_wdata, pf_rdata;
    logic              pf_busy;
    logic              nv_write;

    assign rq.op   = wpc_op_e'(req_op);
    assign rq.bank = req_bank;
    assign rq.idx  = req_idx;
    assign rq.data = req_wdata;
    assign addr    = slot_of(rq.bank, rq.idx);

    assign nv_write = req_valid && (rq.op == OP_WR_PRESET || rq.op == OP_STORE);

    always_comb begin
        wcmd       = WCMD_HOLD;
        wload      = rq.data;
        pf_we      = 1'b0;
        pf_wdata   = (rq.op == OP_STORE) ? wiper : rq.data;
        rsp_d      = '0;
        rsp_d.valid = req_valid;
        rsp_d.ok    = req_valid;
        if (req_valid) begin
            unique case (rq.op)
                OP_RD_WIPER:  rsp_d.data = wiper;
                OP_WR_WIPER:  wcmd = WCMD_LOAD;
                OP_RD_PRESET: rsp_d.data = pf_rdata;
                OP_LOAD: begin
                    wcmd  = WCMD_LOAD;
                    wload = pf_rdata;
                end
                OP_STEP:      wcmd = rq.data[0] ? WCMD_UP : WCMD_DOWN;
                default: ;
            endcase
            if (nv_write) begin
                if (wr_protect || pf_busy) rsp_d.ok = 1'b0;
                else                       pf_we    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    wpc_preset_file #(
        .PROG_CYCLES (PROG_CYCLES),
        .INIT        (PRESET_INIT)
    ) u_presets (
        .clk   (clk),
        .rst   (rst),
        .we    (pf_we),
        .waddr (addr),
        .wdata (pf_wdata),
        .raddr (addr),
        .rdata (pf_rdata),
        .busy  (pf_busy)
    );

    wpc_wiper_reg #(
        .RESET_VAL (RECALL_VAL)
    ) u_wiper (
        .clk      (clk),
        .rst      (rst),
        .cmd      (wcmd),
        .load_val (wload),
        .code     (wiper)
    );

    wpc_tap_decode u_dec (
        .code (wiper),
        .tap  (tap_sel)
    );

    assign rsp_valid = rsp_q.valid;
    assign rsp_ok    = rsp_q.ok;
    assign rsp_data  = rsp_q.data;
    assign busy      = pf_busy;
endmodule

// File: rtl/wpc_chk.sv
module wpc_chk
    import wpc_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic [2:0]   req_op,
    input logic [7:0]   req_wdata,
    input logic         wr_protect,
    input logic         rsp_valid,
    input logic         rsp_ok,
    input logic         busy,
    input logic [7:0]   wiper,
    input logic [255:0] tap_sel
);
    logic is_nv;
    assign is_nv = req_valid && (req_op == OP_WR_PRESET || req_op == OP_STORE);

    // R2
    tap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(tap_sel) == 1) && tap_sel[wiper]);

    // R3
    wiper_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_WR_WIPER) |=> (wiper == $past(req_wdata)) && rsp_ok);

    // R7
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_STEP && req_wdata[0] && wiper != 8'hFF)
        |=> wiper == $past(wiper) + 8'd1);

    // R7
    step_top_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_STEP && req_wdata[0] && wiper == 8'hFF)
        |=> wiper == 8'hFF);

    // R7
    step_bot_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_STEP && !req_wdata[0] && wiper == 8'h00)
        |=> wiper == 8'h00);

    // R8
    protect_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (is_nv && wr_protect) |=> !rsp_ok);

    // R9
    busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (is_nv && busy) |=> !rsp_ok);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (is_nv && !busy && !wr_protect) |=> busy);

    // R10
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
endmodule

bind wiper_preset_core wpc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_wdata  (req_wdata),
    .wr_protect (wr_protect),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .busy       (busy),
    .wiper      (wiper),
    .tap_sel    (tap_sel)
);

// File: tb/sim_wiper_preset_core.sv
`timescale 1ns/1ps
module sim_wiper_preset_core;
    localparam int PROG = 6;
    localparam logic [127:0] INIT = 128'h11223344_55667788_99aabbcc_ddeeff5a;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [2:0]   req_op = 3'd0;
    logic [1:0]   req_bank = 2'd0;
    logic [1:0]   req_idx = 2'd0;
    logic [7:0]   req_wdata = 8'd0;
    logic         wr_protect = 1'b0;
    logic         rsp_valid, rsp_ok, busy;
    logic [7:0]   rsp_data, wiper;
    logic [255:0] tap_sel;

    always #4 clk = ~clk;

    wiper_preset_core #(.PROG_CYCLES(PROG), .PRESET_INIT(INIT)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_idx(req_idx), .req_wdata(req_wdata),
        .wr_protect(wr_protect), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_data(rsp_data), .busy(busy), .wiper(wiper), .tap_sel(tap_sel)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // behavioural reference state
    int m_mem[16];
    int m_wiper;
    int m_cnt;
    int e_valid, e_ok, e_data;
    string e_tag;

    task automatic chk(input bit good, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!good) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [255:0] exp_tap;
        exp_tap = 256'd1 << m_wiper;
        chk(int'(wiper) == m_wiper, "R3", {"wiper after ", e_tag}, wiper, m_wiper);
        chk(tap_sel == exp_tap, "R2", {"tap one-hot after ", e_tag}, $countones(tap_sel), 1);
        chk(int'(busy) == int'(m_cnt != 0), "R9", {"busy after ", e_tag}, busy, int'(m_cnt != 0));
        chk(int'(rsp_valid) == e_valid, "R10", {"rsp_valid after ", e_tag}, rsp_valid, e_valid);
        if (e_valid != 0) begin
            chk(int'(rsp_ok) == e_ok, "R8", {"rsp_ok after ", e_tag}, rsp_ok, e_ok);
            chk(int'(rsp_data) == e_data, "R4", {"rsp_data after ", e_tag}, rsp_data, e_data);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_mem[i] = int'(INIT[i*8 +: 8]);
        m_wiper = m_mem[0];
        m_cnt = 0; e_valid = 0; e_ok = 0; e_data = 0;
    endtask

    // one cycle: check state of the previous edge, then drive and predict
    task automatic cyc(input bit v, input int op, input int bank, input int idx,
                       input int data, input bit wp, input string tag);
        int a;
        bit started;
        @(negedge clk);
        compare();
        req_valid = v; req_op = 3'(op); req_bank = 2'(bank); req_idx = 2'(idx);
        req_wdata = 8'(data); wr_protect = wp;
        e_tag = tag;
        a = bank * 4 + idx;
        started = 1'b0;
        e_valid = int'(v); e_ok = 1; e_data = 0;
        if (v) begin
            case (op)
                1: e_data = m_wiper;
                2: m_wiper = data & 8'hFF;
                3: e_data = m_mem[a];
                4, 6: begin
                    if (wp || m_cnt != 0) e_ok = 0;
                    else begin
                        m_mem[a] = (op == 4) ? (data & 8'hFF) : m_wiper;
                        started = 1'b1;
                    end
                end
                5: m_wiper = m_mem[a];
                7: begin
                    if (data % 2 == 1) begin if (m_wiper < 255) m_wiper++; end
                    else begin if (m_wiper > 0) m_wiper--; end
                end
                default: ;
            endcase
        end
        if (started) m_cnt = PROG;
        else if (m_cnt > 0) m_cnt--;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 0, 0, 0, 0, 1'b0, "idle");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lf;
        model_reset();
        e_tag = "reset";
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: recall of bank 0 slot 0, all presets at init values
        cyc(1'b0, 0, 0, 0, 0, 1'b0, "R1 reset");
        chk(wiper == INIT[7:0], "R1", "recalled wiper", wiper, INIT[7:0]);
        for (int s = 0; s < 16; s++) cyc(1'b1, 3, s / 4, s % 4, 0, 1'b0, "R1 preset read");
        cyc(1'b1, 1, 0, 0, 0, 1'b0, "R3 wiper read");
        // R2/R3 end codes
        cyc(1'b1, 2, 0, 0, 8'h00, 1'b0, "R2 code 00");
        cyc(1'b1, 7, 0, 0, 0, 1'b0, "R7 down at 00");
        cyc(1'b1, 7, 0, 0, 0, 1'b0, "R7 down at 00 again");
        cyc(1'b1, 2, 0, 0, 8'hFF, 1'b0, "R2 code FF");
        cyc(1'b1, 7, 0, 0, 1, 1'b0, "R7 up at FF");
        cyc(1'b1, 7, 0, 0, 0, 1'b0, "R7 down from FF");
        cyc(1'b1, 7, 0, 0, 1, 1'b0, "R7 up to FF");
        cyc(1'b1, 1, 0, 0, 0, 1'b0, "R3 read FF");
        // R4 and R9: write, then write/store while busy, reads allowed
        cyc(1'b1, 4, 2, 3, 8'h5A, 1'b0, "R4 preset write");
        cyc(1'b1, 3, 2, 3, 0, 1'b0, "R4 readback");
        cyc(1'b1, 4, 1, 1, 8'h33, 1'b0, "R9 write while busy");
        cyc(1'b1, 6, 1, 1, 0, 1'b0, "R9 store while busy");
        cyc(1'b1, 3, 1, 1, 0, 1'b0, "R9 read unchanged");
        cyc(1'b1, 2, 0, 0, 8'h40, 1'b0, "R3 wiper write while busy");
        idle(PROG);
        // R8 protect
        cyc(1'b1, 4, 3, 0, 8'hC3, 1'b1, "R8 protected write");
        cyc(1'b1, 6, 3, 0, 0, 1'b1, "R8 protected store");
        cyc(1'b1, 3, 3, 0, 0, 1'b0, "R8 slot unchanged");
        cyc(1'b1, 2, 0, 0, 8'h21, 1'b1, "R3 wiper write under protect");
        // R5 load and R6 store
        cyc(1'b1, 5, 2, 3, 0, 1'b0, "R5 load preset");
        cyc(1'b1, 2, 0, 0, 8'h9E, 1'b0, "R6 set wiper");
        cyc(1'b1, 6, 1, 0, 0, 1'b0, "R6 store");
        cyc(1'b1, 3, 1, 0, 0, 1'b0, "R6 readback");
        idle(PROG + 1);
        cyc(1'b1, 0, 0, 0, 0, 1'b0, "R10 nop");
        // mixed stream
        lf = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[8] | lf[9], int'(lf[2:0]), int'(lf[4:3]), int'(lf[6:5]),
                int'(lf[14:7]), lf[15] & lf[11], "mixed");
        end
        idle(1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule